// File: doc/BRIEF.md
# External interrupt line conditioner

This block sits between three external interrupt pins and a downstream interrupt controller. That controller only understands active-high levels and rising edges. Each pin therefore gets its own programmable trigger type, and the block converts whatever the pin does into one of those two forms. An active-low level is inverted to active-high. A falling edge is turned into a one-cycle high pulse, the same as a rising edge. Each line drives one output, so line n feeds controller input n.

All three control bytes are packed into one shared 24-bit control word, which is the low three bytes of a 32-bit register slot. Software reaches the word over a plain write port with per-byte enables and a read port that always shows the current contents. Every byte holds four things: the line's trigger type, an enable, a sampling-rate select and a pending flag. An edge-triggered line latches each detected edge in its pending flag, and the flag stays set until software writes a one to it. A level-triggered line needs no clearing; for such a line the flag position shows the conditioned level. Each pin passes through a two-flop synchronizer. The synchronizer advances on every clock when fast sampling is selected. Otherwise it advances only on cycles where the slow sampling strobe is high.

Top module: `xirq_conditioner`

## Requirements
- R1: After reset `bus_rdata` and `irq_out` are all zero. Line 0 occupies word bits 23:16, line 1 bits 15:8 and line 2 bits 7:0. Byte bits 3:1 always read 0, whatever value is written to them.
- R2: Each control byte has the following fields. Bits 7:6 are the trigger type: 00 level high, 01 level low, 10 rising edge, 11 falling edge. Bit 5 is enable. Bit 4 selects fast sampling. Bit 0 is the pending flag. A write stores bits 7:4, and these read back on the next cycle.
- R3: A write changes only the bytes whose enable is set. `bus_be[2]` selects line 0, `bus_be[1]` selects line 1 and `bus_be[0]` selects line 2.
- R4: For an enabled level-high line with fast sampling, `irq_out` equals the pin value. The output takes the new value on the third rising clock edge after the pin changes.
- R5: For an enabled level-low line, `irq_out` is the inverted pin value, with the same latency as R4.
- R6: For an enabled rising-edge line, a low-to-high pin transition gives a `irq_out` pulse exactly one cycle wide, on the third clock edge. In the same cycle the pending flag becomes 1. A high-to-low transition does neither.
- R7: For an enabled falling-edge line, a high-to-low pin transition gives the same one-cycle pulse and sets pending. A low-to-high transition does neither.
- R8: An edge line's pending flag stays set until a write with byte bit 0 equal to 1 clears it. A write with bit 0 equal to 0 leaves the flag unchanged. If an edge arrives in the same cycle as a clear, the edge wins.
- R9: A disabled line holds its `irq_out` at 0. An edge that arrives while the line is disabled does not set pending.
- R10: With fast sampling off, the synchronizer advances only on cycles where `slow_tick` is 1. A pin change has no effect on the output while `slow_tick` stays 0.
- R11: For a level-type line, bit 0 of the byte reads the conditioned level (the pin, inverted for level low), whether or not the line is enabled. Writing 1 to that bit has no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Sampling strobe for lines with fast sampling off |
| irq_pin | input | 3 | External interrupt pins, bit n is line n |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_be | input | 3 | Byte enables, bit n covers word bits 8n+7:8n |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Current control word |
| irq_out | output | 3 | Normalized interrupt outputs, bit n is line n |

## Verification
The hardest case to reach is an edge arriving while the line is disabled, combined with a pending flag that must survive writes with bit 0 clear. Both need a sequence of register writes between pin moves, not a single stimulus. The bench gets there with directed sequences, then with a seeded random run. In the random run each round rewrites one line with a random type and enable and a random clear bit, then toggles its pin at random. Every output and read-back is compared with a bench model at the exact cycle.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'b00,
        TRIG_LOW  = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_e;

    // writable configuration bits and the pending position inside one byte
    localparam logic [7:0] CFG_MASK  = 8'hF0;
    localparam logic [7:0] PEND_MASK = 8'h01;
    localparam int         CFG_LSB   = 4;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    typedef struct packed {
        trig_e trig;
        logic  en;
        logic  fast;
        logic  pend;
        logic  out;
    } line_t;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample) begin
            st_d.s1 = pin;
            st_d.s2 = st_q.s1;
            st_d.s3 = st_q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;
    assign rise  = sample &  st_q.s2 & ~st_q.s3;
    assign fall  = sample & ~st_q.s2 &  st_q.s3;

    // R10
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(level));

endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       pin,
    input  logic       wr_hit,
    input  logic [7:0] wr_byte,
    output logic [7:0] ctrl_byte,
    output logic       irq
);

    line_t      st_d, st_q;
    logic       sample, lvl, rise, fall;
    logic       is_edge, inv, cond_lvl, edge_hit, clr;
    logic [3:0] cfg;

    assign sample = st_q.fast | slow_tick;

    xirq_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .pin    (pin),
        .level  (lvl),
        .rise   (rise),
        .fall   (fall)
    );

    always_comb begin
        is_edge  = st_q.trig[1];
        inv      = st_q.trig[0];
        cond_lvl = lvl ^ inv;
        edge_hit = inv ? fall : rise;
        cfg      = 4'((wr_byte & CFG_MASK) >> CFG_LSB);
        clr      = wr_hit && ((wr_byte & PEND_MASK) != 8'h00);

        st_d = st_q;
        if (wr_hit) begin
            st_d.trig = trig_e'(cfg[3:2]);
            st_d.en   = cfg[1];
            st_d.fast = cfg[0];
        end
        if (clr) st_d.pend = 1'b0;
        if (is_edge && st_q.en && edge_hit) st_d.pend = 1'b1;
        st_d.out = st_q.en & (is_edge ? edge_hit : cond_lvl);

        ctrl_byte = {st_q.trig, st_q.en, st_q.fast, 3'b000,
                     is_edge ? st_q.pend : cond_lvl};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.out;

    // R6 R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out && is_edge && !wr_hit) |=> !st_q.out);

    // R9
    mask_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> !st_q.out);

    // R9
    no_latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pend && !st_q.en) |=> !st_q.pend);

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !clr) |=> st_q.pend);

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise && !fall) |=> !st_q.pend);

endmodule

// File: rtl/xirq_conditioner.sv
module xirq_conditioner
    import xirq_pkg::*;
#(
    parameter int NLINES = 3,
    localparam int REG_W = 8 * NLINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic [NLINES-1:0] irq_pin,
    input  logic              bus_wr,
    input  logic [NLINES-1:0] bus_be,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NLINES-1:0] irq_out
);

    logic [7:0] byte_rd [NLINES];

    // line n lives in byte lane NLINES-1-n: line 0 takes the top byte
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        localparam int LANE = NLINES - 1 - i;

        xirq_line u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .slow_tick (slow_tick),
            .pin       (irq_pin[i]),
            .wr_hit    (bus_wr & bus_be[LANE]),
            .wr_byte   (bus_wdata[LANE*8 +: 8]),
            .ctrl_byte (byte_rd[i]),
            .irq       (irq_out[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NLINES; i++) begin
            bus_rdata[(NLINES-1-i)*8 +: 8] = byte_rd[i];
        end
    end

endmodule

// File: tb/xirq_conditioner_test.sv
module xirq_conditioner_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic [2:0]  irq_pin = 3'b000;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_be = 3'b000;
    logic [23:0] bus_wdata = '0;
    logic [23:0] bus_rdata;
    logic [2:0]  irq_out;

    int nvec = 0;
    int nerr = 0;
    bit done = 1'b0;

    // bench model
    logic [1:0] m_trig [3];
    logic       m_en   [3];
    logic       m_fast [3];
    logic       m_pend [3];
    logic       m_pin  [3];

    always #5 clk = ~clk;

    xirq_conditioner uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .irq_pin   (irq_pin),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic lvl_out(input int i);
        return m_en[i] & ~m_trig[i][1] & (m_pin[i] ^ m_trig[i][0]);
    endfunction

    function automatic logic [2:0] exp_steady();
        logic [2:0] v;
        for (int i = 0; i < 3; i++) v[i] = lvl_out(i);
        return v;
    endfunction

    function automatic logic [23:0] exp_rdata();
        logic [23:0] w = '0;
        for (int i = 0; i < 3; i++) begin
            w[(2-i)*8 +: 8] = {m_trig[i], m_en[i], m_fast[i], 3'b000,
                               m_trig[i][1] ? m_pend[i] : (m_pin[i] ^ m_trig[i][0])};
        end
        return w;
    endfunction

    task automatic wr(input logic [2:0] be, input logic [23:0] data);
        bus_wr = 1'b1; bus_be = be; bus_wdata = data;
        cyc(1);
        bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic set_line(input int i, input logic [1:0] trig, input logic en,
                            input logic fast, input logic clr, input string req);
        logic [7:0] b = {trig, en, fast, 3'b111, clr};   // bits 3:1 written as 1
        wr(3'b001 << (2-i), 24'(b) << ((2-i)*8));
        m_trig[i] = trig; m_en[i] = en; m_fast[i] = fast;
        if (clr) m_pend[i] = 1'b0;
        cyc(3);
        check({req, " config readback"}, 32'(bus_rdata), 32'(exp_rdata()));
        check({req, " settled out"}, 32'(irq_out), 32'(exp_steady()));
    endtask

    task automatic pin_step(input int i, input logic v, input string req);
        logic old = m_pin[i];
        logic fired;
        logic [2:0] e;
        irq_pin[i] = v;
        cyc(2);
        check({req, " before latency"}, 32'(irq_out), 32'(exp_steady()));
        cyc(1);
        m_pin[i] = v;
        fired = m_trig[i][1] && (m_trig[i][0] ? (old & ~v) : (~old & v));
        if (fired && m_en[i]) m_pend[i] = 1'b1;
        e = exp_steady();
        e[i] = m_trig[i][1] ? (fired & m_en[i]) : lvl_out(i);
        check({req, " out after edge"}, 32'(irq_out), 32'(e));
        check({req, " readback"}, 32'(bus_rdata), 32'(exp_rdata()));
        cyc(1);
        check({req, " pulse end"}, 32'(irq_out), 32'(exp_steady()));
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            m_trig[i] = 2'b00; m_en[i] = 0; m_fast[i] = 0; m_pend[i] = 0; m_pin[i] = 0;
        end
        void'($urandom(32'd1234));
        cyc(3);
        // R1 reset state
        check("R1 reset rdata", 32'(bus_rdata), 32'h0);
        check("R1 reset out", 32'(irq_out), 32'h0);
        rst_n = 1'b1;
        cyc(2);

        // R1 R2: full word write, reserved bits 3:1 read back 0
        wr(3'b111, 24'hBF_7E_31);
        m_trig[0] = 2'b10; m_en[0] = 1; m_fast[0] = 1;
        m_trig[1] = 2'b01; m_en[1] = 1; m_fast[1] = 1;
        m_trig[2] = 2'b00; m_en[2] = 1; m_fast[2] = 1;
        cyc(2);
        check("R2 R1 field layout", 32'(bus_rdata), 32'(exp_rdata()));
        check("R5 idle low pin level-low out", 32'(irq_out), 32'(exp_steady()));

        // R3 byte enable on line 1 only
        wr(3'b010, 24'hFF_00_FF);
        m_trig[1] = 2'b00; m_en[1] = 0; m_fast[1] = 0;
        cyc(1);
        check("R3 lane isolation", 32'(bus_rdata), 32'(exp_rdata()));

        // R4 level high
        set_line(0, 2'b00, 1, 1, 1, "R4");
        pin_step(0, 1, "R4 rise");
        pin_step(0, 0, "R4 fall");
        // R5 level low
        set_line(1, 2'b01, 1, 1, 0, "R5");
        pin_step(1, 1, "R5 rise");
        pin_step(1, 0, "R5 fall");
        // R11 pending bit of level line, write 1 has no effect, also when disabled
        set_line(1, 2'b01, 0, 1, 1, "R11");
        pin_step(1, 1, "R11 level read disabled");
        pin_step(1, 0, "R11 level read");
        // R6 rising edge
        set_line(2, 2'b10, 1, 1, 1, "R6");
        pin_step(2, 1, "R6 rising");
        pin_step(2, 0, "R6 wrong dir");
        // R8 write with bit0=0 keeps pending, bit0=1 clears
        set_line(2, 2'b10, 1, 1, 0, "R8 keep");
        set_line(2, 2'b10, 1, 1, 1, "R8 clear");
        // R7 falling edge
        set_line(0, 2'b11, 1, 1, 0, "R7");
        pin_step(0, 1, "R7 wrong dir");
        pin_step(0, 0, "R7 falling");
        set_line(0, 2'b11, 1, 1, 1, "R7 clear");
        // R9 disabled edges not latched, level masked
        set_line(2, 2'b10, 0, 1, 0, "R9");
        pin_step(2, 1, "R9 edge while off");
        set_line(1, 2'b00, 0, 1, 0, "R9 level");
        pin_step(1, 1, "R9 level masked");
        pin_step(1, 0, "R9 level masked low");

        // R10 slow sampling
        set_line(0, 2'b00, 1, 0, 0, "R10");
        irq_pin[0] = 1'b1;
        cyc(10);
        check("R10 no advance without tick", 32'(irq_out[0]), 32'h0);
        slow_tick = 1'b1;
        cyc(3);
        slow_tick = 1'b0;
        cyc(1);
        m_pin[0] = 1'b1;
        check("R10 advance on ticks", 32'(irq_out[0]), 32'h1);
        set_line(0, 2'b00, 1, 1, 0, "R10 back to fast");

        // random rounds, fast sampling
        for (int r = 0; r < 300; r++) begin
            int i = $urandom_range(0, 2);
            set_line(i, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0), 1'b1,
                     1'($urandom_range(0, 1)), "R2 R8 random cfg");
            for (int k = 0; k < 3; k++) begin
                int t;
                logic v;
                t = $urandom_range(0, 1);
                v = 1'(t);
                case (m_trig[i])
                    2'b00:   pin_step(i, v, "R4 random");
                    2'b01:   pin_step(i, v, "R5 random");
                    2'b10:   pin_step(i, v, "R6 random");
                    default: pin_step(i, v, "R7 random");
                endcase
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule